// File: doc/BRIEF.md
# Glitch-Free Dual Output Clock Divider

This block takes one fast source clock and derives two divided clocks from it. Each of the two dividers has its own 3-bit ratio code, drawn from a fixed set of eight ratios. Both dividers count in lockstep from a shared starting point, so every rising edge that the two outputs should share falls on the same source edge. A change of ratio never cuts a pulse short. The divider finishes its current period and then holds its output low. Both dividers then restart together on the new ratios.

Around the dividers sits a small output stage. Output 0 always carries divider 0. One select bit chooses whether output 1 carries divider 0 or divider 1. Each output has an enable, which also drives that output's output-enable pin, since the pad is tri-stated when disabled. A global force-low bit pulls both outputs to 0. Ratio 1 is special: the output is the source clock itself, gated, during the high phase of the source clock.

Top module: `dual_clkdiv`

## Requirements
- R1: The ratio code maps as 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8 and 7→16. For a ratio R of 2 or more, the divided level is high for floor(R/2) source cycles and low for the rest of each R-cycle period, so ratios 3 and 5 are high for one cycle fewer than they are low. The first high period starts on the first source rising edge after reset is released.
- R2: With ratio 1, the output follows the high phase of the source clock in every source cycle. It is low during the low phase.
- R3: Both dividers always restart from count zero on the same source edge. This happens after reset and after every ratio change, even when only one of the two codes changed, so their periods begin together.
- R4: A ratio code that differs from the active ratio takes effect only at the end of a whole period. Each divider completes the period it is in, then holds low. Both start on the new ratios in the source cycle after the later of the two period ends.
- R5: While force-low is 1, both outputs are 0 from the next source rising edge onward. The output-enable pins are unaffected.
- R6: Clearing an output's enable bit makes that output 0 and its output-enable pin 0 from the next source rising edge onward. Setting the bit drives the pin 1.
- R7: Output 0 always carries divider 0. Output 1 carries divider 1 when the select bit is 1 and divider 0 when it is 0. A new select value applies from the next source rising edge.
- R8: While reset is high, both outputs and both output-enable pins are 0. The ratio codes present during reset become the active ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | 1 | Source clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio0_i | input | 3 | Ratio code for divider 0 |
| ratio1_i | input | 3 | Ratio code for divider 1 |
| force_low_i | input | 1 | Drives both outputs low when 1 |
| out_en_i | input | 2 | Per-output enable, bit n for output n |
| out1_from_div1_i | input | 1 | 1: output 1 carries divider 1, 0: divider 0 |
| clk_o | output | 2 | Divided clock outputs |
| oe_o | output | 2 | Output-enable per output, 0 means high impedance |

## Verification
The checks assume the following about the inputs:
- All control inputs change only between source rising edges, and never next to the falling edge that captures the ratio-1 gate.
- A ratio code is not changed again until the restart that the previous change triggered has taken place.
- A ratio code is never moved back to the active value while a restart is still pending.

The stimulus drives every input three time units after a rising edge, ahead of the falling edge. It holds each ratio pair for forty source cycles, which is longer than the longest wait for a restart.

// File: rtl/dual_clkdiv_pkg.sv
package dual_clkdiv_pkg;

    localparam int NUM_DIV = 2;
    localparam int CODE_W  = 3;
    localparam int CNT_W   = 4;

    typedef logic [CODE_W-1:0] ratio_code_t;
    typedef logic [CNT_W-1:0]  div_cnt_t;

    // Per-divider status handed to the sync and output logic
    typedef struct packed {
        logic at_end;   // last source cycle of the current period
        logic parked;   // holding low, waiting for the common restart
        logic hi;       // divided level for ratios 2 and above
        logic pass;     // ratio 1 active: source clock passes through
    } div_stat_t;

    // Final count value of a period (ratio minus one)
    function automatic div_cnt_t last_count(ratio_code_t code);
        case (code)
            3'd6:    return div_cnt_t'(7);
            3'd7:    return div_cnt_t'(15);
            default: return div_cnt_t'(code);
        endcase
    endfunction

    // Number of high cycles per period (ratio divided by two, rounded down)
    function automatic div_cnt_t high_count(ratio_code_t code);
        div_cnt_t r;
        case (code)
            3'd6:    r = div_cnt_t'(8);
            3'd7:    r = div_cnt_t'(0);
            default: r = div_cnt_t'(code) + div_cnt_t'(1);
        endcase
        if (code == 3'd7) return div_cnt_t'(8);
        return r >> 1;
    endfunction

endpackage

// File: rtl/dual_clkdiv_div.sv
module dual_clkdiv_div
    import dual_clkdiv_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        load_i,
    input  logic        park_req_i,
    input  ratio_code_t code_i,
    output div_stat_t   stat_o,
    output div_cnt_t    cnt_o,
    output ratio_code_t code_o
);

    div_cnt_t    cnt_q;
    ratio_code_t code_q;
    logic        park_q;
    logic        at_end;

    assign at_end = (cnt_q == last_count(code_q));

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            cnt_q  <= '0;
            code_q <= code_i;
            park_q <= 1'b0;
        end else if (!park_q) begin
            if (at_end) begin
                if (park_req_i) begin
                    park_q <= 1'b1;
                end else begin
                    cnt_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q + div_cnt_t'(1);
            end
        end
    end

    always_comb begin
        stat_o.at_end = at_end && !park_q;
        stat_o.parked = park_q;
        stat_o.hi     = !park_q && (code_q != '0) && (cnt_q < high_count(code_q));
        stat_o.pass   = !park_q && (code_q == '0);
    end

    assign cnt_o  = cnt_q;
    assign code_o = code_q;

endmodule

// File: rtl/dual_clkdiv_sync.sv
module dual_clkdiv_sync
    import dual_clkdiv_pkg::*;
(
    input  ratio_code_t [NUM_DIV-1:0] cfg_i,
    input  ratio_code_t [NUM_DIV-1:0] act_i,
    input  div_stat_t   [NUM_DIV-1:0] stat_i,
    output logic                      pend_o,
    output logic                      load_o
);

    logic pend;
    logic ready;
    logic any_parked;

    always_comb begin
        pend       = 1'b0;
        ready      = 1'b1;
        any_parked = 1'b0;
        for (int d = 0; d < NUM_DIV; d++) begin
            pend       = pend | (cfg_i[d] != act_i[d]);
            ready      = ready & (stat_i[d].parked | stat_i[d].at_end);
            any_parked = any_parked | stat_i[d].parked;
        end
    end

    assign pend_o = pend;
    // restart once every divider sits at a period end or is parked
    assign load_o = ready & (pend | any_parked);

endmodule

// File: rtl/dual_clkdiv_out.sv
module dual_clkdiv_out
    import dual_clkdiv_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      force_low_i,
    input  logic [NUM_DIV-1:0]        en_i,
    input  logic                      sel_i,
    input  div_stat_t [NUM_DIV-1:0]   stat_i,
    output logic [NUM_DIV-1:0]        lvl_o,
    output logic [NUM_DIV-1:0]        oe_o,
    output logic [NUM_DIV-1:0]        clk_o
);

    logic [NUM_DIV-1:0] src_hi;
    logic [NUM_DIV-1:0] src_pass;
    logic [NUM_DIV-1:0] gate;
    logic [NUM_DIV-1:0] lvl_q;
    logic [NUM_DIV-1:0] oe_q;
    logic [NUM_DIV-1:0] pass_q;

    for (genvar o = 0; o < NUM_DIV; o++) begin : g_route
        if (o == 0) begin : g_first
            assign src_hi[o]   = stat_i[0].hi;
            assign src_pass[o] = stat_i[0].pass;
        end else begin : g_other
            assign src_hi[o]   = sel_i ? stat_i[o].hi   : stat_i[0].hi;
            assign src_pass[o] = sel_i ? stat_i[o].pass : stat_i[0].pass;
        end
        assign gate[o] = en_i[o] & ~force_low_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q <= '0;
            oe_q  <= '0;
        end else begin
            lvl_q <= gate & src_hi;
            oe_q  <= en_i;
        end
    end

    // ratio-1 gate changes only while the source clock is low
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            pass_q <= '0;
        end else begin
            pass_q <= gate & src_pass;
        end
    end

    assign lvl_o = lvl_q;
    assign oe_o  = oe_q;
    assign clk_o = lvl_q | ({NUM_DIV{clk_i}} & pass_q);

endmodule

// File: rtl/dual_clkdiv.sv
module dual_clkdiv
    import dual_clkdiv_pkg::*;
(
    input  logic       clk_src_i,
    input  logic       rst_i,
    input  logic [2:0] ratio0_i,
    input  logic [2:0] ratio1_i,
    input  logic       force_low_i,
    input  logic [1:0] out_en_i,
    input  logic       out1_from_div1_i,
    output logic [1:0] clk_o,
    output logic [1:0] oe_o
);

    ratio_code_t [NUM_DIV-1:0] cfg_w;
    ratio_code_t [NUM_DIV-1:0] code_w;
    div_cnt_t    [NUM_DIV-1:0] cnt_w;
    div_stat_t   [NUM_DIV-1:0] stat_w;
    logic        [NUM_DIV-1:0] lvl_w;
    logic                      pend_w;
    logic                      load_w;

    assign cfg_w = {ratio1_i, ratio0_i};

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        dual_clkdiv_div u_div (
            .clk_i      (clk_src_i),
            .rst_i      (rst_i),
            .load_i     (load_w),
            .park_req_i (pend_w),
            .code_i     (cfg_w[d]),
            .stat_o     (stat_w[d]),
            .cnt_o      (cnt_w[d]),
            .code_o     (code_w[d])
        );
    end

    dual_clkdiv_sync u_sync (
        .cfg_i  (cfg_w),
        .act_i  (code_w),
        .stat_i (stat_w),
        .pend_o (pend_w),
        .load_o (load_w)
    );

    dual_clkdiv_out u_out (
        .clk_i       (clk_src_i),
        .rst_i       (rst_i),
        .force_low_i (force_low_i),
        .en_i        (out_en_i),
        .sel_i       (out1_from_div1_i),
        .stat_i      (stat_w),
        .lvl_o       (lvl_w),
        .oe_o        (oe_o),
        .clk_o       (clk_o)
    );

endmodule

// File: rtl/dual_clkdiv_chk.sv
module dual_clkdiv_chk
    import dual_clkdiv_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      force_low,
    input logic [1:0]                out_en,
    input logic                      out1_sel,
    input logic [1:0]                lvl,
    input logic [1:0]                oe,
    input div_cnt_t    [NUM_DIV-1:0] cnt,
    input ratio_code_t [NUM_DIV-1:0] code
);

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (lvl == 2'b00 && oe == 2'b00));

    a_r1_count0_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt[0] <= last_count(code[0]));

    a_r1_count1_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt[1] <= last_count(code[1]));

    a_r3_codes_move_together: assert property (@(posedge clk) disable iff (rst)
        (code[0] != $past(code[0]) || code[1] != $past(code[1]))
        |-> (cnt[0] == '0 && cnt[1] == '0));

    a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
        force_low |=> (lvl == 2'b00));

    a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
        (out_en != 2'b11) |=> ((lvl & ~$past(out_en)) == 2'b00));

    a_r7_out1_from_div0: assert property (@(posedge clk) disable iff (rst)
        (!out1_sel && out_en == 2'b11 && !force_low) |=> (lvl[1] == lvl[0]));

endmodule

bind dual_clkdiv dual_clkdiv_chk u_chk (
    .clk       (clk_src_i),
    .rst       (rst_i),
    .force_low (force_low_i),
    .out_en    (out_en_i),
    .out1_sel  (out1_from_div1_i),
    .lvl       (lvl_w),
    .oe        (oe_o),
    .cnt       (cnt_w),
    .code      (code_w)
);

// File: tb/dual_clkdiv_tb.sv
module dual_clkdiv_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] r0  = 3'd3;
    logic [2:0] r1  = 3'd2;
    logic       force_lo = 1'b0;
    logic [1:0] en  = 2'b11;
    logic       sel = 1'b1;
    logic [1:0] clk_o;
    logic [1:0] oe_o;

    dual_clkdiv u_dut (
        .clk_src_i        (clk),
        .rst_i            (rst),
        .ratio0_i         (r0),
        .ratio1_i         (r1),
        .force_low_i      (force_lo),
        .out_en_i         (en),
        .out1_from_div1_i (sel),
        .clk_o            (clk_o),
        .oe_o             (oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = -4;
    string tag    = "R8";
    bit    chk_on = 1'b0;

    // model of active and previous ratio schedules
    int rn[2], bn[2], ro[2], bo[2], eo[2];
    logic [1:0] m_en    = 2'b11;
    logic       m_force = 1'b0;
    logic       m_sel   = 1'b1;

    // next input values, applied inside tick
    logic [2:0] nx_r0 = 3'd3, nx_r1 = 3'd2;
    logic [1:0] nx_en = 2'b11;
    logic       nx_force = 1'b0, nx_sel = 1'b1, nx_rst = 1'b1;

    function automatic int ratio_of(logic [2:0] c);
        if (c == 3'd7) return 16;
        if (c == 3'd6) return 8;
        return int'(c) + 1;
    endfunction

    function automatic logic pat(int r, int pos, bit hi_phase);
        if (r == 1) return hi_phase;
        return ((pos % r) < (r / 2));
    endfunction

    function automatic logic lvl(int d, int c, bit hi_phase);
        if (c >= bn[d]) return pat(rn[d], c - bn[d], hi_phase);
        if (c <= eo[d]) return pat(ro[d], c - bo[d], hi_phase);
        return 1'b0;
    endfunction

    function automatic logic [1:0] expect_out(int c, bit hi_phase);
        logic [1:0] e;
        e[0] = m_en[0] & ~m_force & lvl(0, c, hi_phase);
        e[1] = m_en[1] & ~m_force & lvl(m_sel ? 1 : 0, c, hi_phase);
        return e;
    endfunction

    task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    task automatic apply();
        int t;
        int e[2];
        int cs;
        int nr[2];
        t = cyc + 1;
        nr[0] = ratio_of(nx_r0);
        nr[1] = ratio_of(nx_r1);
        if (rst && !nx_rst) begin
            for (int d = 0; d < 2; d++) begin
                rn[d] = nr[d]; bn[d] = 0; ro[d] = nr[d]; bo[d] = 0; eo[d] = -1;
            end
        end else if (!rst && (nr[0] != rn[0] || nr[1] != rn[1])) begin
            cs = 0;
            for (int d = 0; d < 2; d++) begin
                e[d] = t + (rn[d] - 1 - ((t - bn[d]) % rn[d]));
                if (e[d] > cs) cs = e[d];
            end
            for (int d = 0; d < 2; d++) begin
                ro[d] = rn[d]; bo[d] = bn[d]; eo[d] = e[d];
                rn[d] = nr[d]; bn[d] = cs + 1;
            end
        end
        rst = nx_rst; r0 = nx_r0; r1 = nx_r1;
        en = nx_en; force_lo = nx_force; sel = nx_sel;
        m_en = nx_en; m_force = nx_force; m_sel = nx_sel;
    endtask

    task automatic tick();
        logic [1:0] exp_lo;
        bit         rst_phase;
        @(posedge clk);
        cyc++;
        #2;
        rst_phase = rst;
        exp_lo = 2'b00;
        if (rst_phase) begin
            check("R8", "clk in reset", clk_o, 2'b00);
            check("R8", "oe in reset", oe_o, 2'b00);
        end else if (chk_on) begin
            check(tag, "clk high phase", clk_o, expect_out(cyc, 1'b1));
            check("R6", "oe", oe_o, m_en);
            exp_lo = expect_out(cyc, 1'b0);
        end
        #1;
        apply();
        #4;
        if (rst_phase) begin
            check("R8", "clk low phase in reset", clk_o, 2'b00);
        end else if (chk_on) begin
            check(tag, "clk low phase", clk_o, exp_lo);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        tick();
        tick();
        nx_rst = 1'b0;
        tick();
        chk_on = 1'b1;

        tag = "R1";
        run(40);

        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                nx_r0 = 3'(a);
                nx_r1 = 3'(b);
                tag = (a == 0 || b == 0) ? "R2" : "R4";
                run(40);
            end
        end

        tag = "R3";
        nx_r0 = 3'd6; nx_r1 = 3'd7;
        run(48);
        nx_r0 = 3'd2; nx_r1 = 3'd4;
        run(40);

        tag = "R7";
        nx_r0 = 3'd1; nx_r1 = 3'd4;
        nx_sel = 1'b0;
        run(30);
        nx_sel = 1'b1;
        run(30);

        tag = "R5";
        nx_force = 1'b1;
        run(10);
        nx_force = 1'b0;
        run(20);

        tag = "R6";
        nx_en = 2'b01;
        run(10);
        nx_en = 2'b10;
        run(10);
        nx_en = 2'b00;
        run(10);
        nx_en = 2'b11;
        run(20);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule